// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a system clock into the bit timing of a CAN receiver. A programmable prescaler sets the length of one time quantum (TQ). Each bit is built from a one-TQ synchronisation slot, a first timing segment and a second timing segment. The receive line is read at the end of the first segment, either once or as a two-of-three vote over the last three quanta. A frame layer uses the sampled bit together with the two strobes, one marking the sample instant and one marking the start of each bit.

Falling edges of the line (recessive 1 to dominant 0) realign the bit grid. When hard synchronisation is enabled, an edge restarts the bit at once. Otherwise an edge that arrives late stretches the first segment, and an edge that arrives early cuts the second segment short. Both corrections are capped by a programmable jump width, and only one correction is made per bit. The configuration is checked against CAN limits. An illegal setting raises an error flag and holds the timing idle.

Top module: `can_bit_timer`

## Requirements
- R1: `cfgErr` is 1 exactly when the configuration breaks any of these rules: first segment 4..16 TQ, second segment 2..8 TQ, jump width 1..4 TQ, jump width no larger than the second segment, first segment strictly longer than the second, and 1 + first + second between 8 and 25 TQ. While `cfgErr` is 1, neither strobe fires and `rxBit` stays 1.
- R2: One TQ lasts `cfgPrescale`+1 clocks. A bit with no correction lasts 1 + `cfgTseg1` + `cfgTseg2` TQ. `bitStart` is high for one clock in the last clock of each bit's synchronisation TQ.
- R3: With no correction, `samplePulse` is high for one clock exactly `cfgTseg1` TQ after `bitStart`, and never in the same clock as `bitStart`.
- R4: `rxBit` is updated in the clock after `samplePulse`. With `cfgTriple`=0 it takes the synchronised line value seen in the sample TQ. `rxBit` is 1 after reset.
- R5: With `cfgTriple`=1, `rxBit` takes the majority of the line values seen in the sample TQ and in the two TQs before it.
- R6: An edge seen in TQ k of the first segment (k counted from 1 after the synchronisation TQ) delays the sample point and the end of the bit by min(k, `cfgSjw`) TQ.
- R7: An edge seen in the second segment, when the last sampled bit was 1, has phase error e, the number of TQs left in the bit counting the edge TQ. If e ≤ `cfgSjw`, the edge TQ ends as a synchronisation TQ, and `bitStart` fires at its end. Otherwise the bit is shortened by `cfgSjw` TQ.
- R8: After a correction in a bit, further edges in that bit are ignored.
- R9: With `cfgHardSyncEn`=1, an edge in any TQ ends that TQ as a synchronisation TQ. `bitStart` fires at its end, and the sample point follows `cfgTseg1` TQ later.
- R10: An edge in the second segment is ignored when the last sampled bit was 0, and the bit keeps its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPrescale | input | PRE_W | Clocks per TQ minus one |
| cfgTseg1 | input | SEG1_W | First segment length in TQ |
| cfgTseg2 | input | SEG2_W | Second segment length in TQ |
| cfgSjw | input | SJW_W | Jump width in TQ |
| cfgTriple | input | 1 | 1 = three-sample majority, 0 = single sample |
| cfgHardSyncEn | input | 1 | 1 = edges restart the bit (bus idle) |
| rxIn | input | 1 | Raw receive line, 1 = recessive |
| rxBit | output | 1 | Sampled bit value |
| samplePulse | output | 1 | One-clock strobe at the sample point |
| bitStart | output | 1 | One-clock strobe at the end of the synchronisation TQ |
| cfgErr | output | 1 | Configuration outside CAN limits |

## Verification
The edge-correction logic and the sample point can act in the same TQ tick. A late edge seen in the TQ that would have been the sample TQ must suppress that sample and move it later. In the same way, a hard-sync edge must replace the sample with a new bit start. The bench provokes this by placing edges at computed TQ offsets from an observed `bitStart`. It then judges the clock in which the next `samplePulse` or `bitStart` appears against offsets derived from the segment lengths and the jump width. A second collision is a second-segment edge arriving after a correction has already been made, or after a dominant sample. It is judged by whether the following bit start keeps its full distance.

// File: rtl/canbt_pkg.sv
package canbt_pkg;
  // CAN segment limits in time quanta
  localparam int SEG1_MIN = 4;
  localparam int SEG1_MAX = 16;
  localparam int SEG2_MIN = 2;
  localparam int SEG2_MAX = 8;
  localparam int JUMP_MIN = 1;
  localparam int JUMP_MAX = 4;
  localparam int BIT_MIN  = 8;
  localparam int BIT_MAX  = 25;

  // control -> datapath strobes
  typedef struct packed {
    logic idle;    // configuration invalid, hold state
    logic tick;    // end of the current time quantum
    logic sample;  // end of the sample-point quantum
  } strobes_t;
endpackage

// File: rtl/canbt_dp.sv
module canbt_dp
  import canbt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgTriple,
  input  logic     rxIn,
  input  strobes_t strb,
  output logic     lineFall,
  output logic     rxBit
);
  logic [1:0] syncFf;
  logic       rxSync;
  logic       prevTq;
  logic [1:0] hist;
  logic       vote;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncFf <= 2'b11;
    else       syncFf <= {syncFf[0], rxIn};
  end
  assign rxSync = syncFf[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTq <= 1'b1;
      hist   <= 2'b11;
      rxBit  <= 1'b1;
    end else if (strb.idle) begin
      prevTq <= 1'b1;
      hist   <= 2'b11;
      rxBit  <= 1'b1;
    end else begin
      if (strb.tick) begin
        prevTq <= rxSync;
        hist   <= {hist[0], rxSync};
      end
      if (strb.sample) rxBit <= cfgTriple ? vote : rxSync;
    end
  end

  assign vote     = (hist[1] & hist[0]) | (hist[1] & rxSync) | (hist[0] & rxSync);
  assign lineFall = prevTq & ~rxSync;

  // R4
  single_sample_chk: assert property (@(posedge clk) disable iff (!rstN || strb.idle)
    (strb.sample && !cfgTriple) |=> (rxBit == $past(rxSync)));

  // R1
  idle_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> rxBit);
endmodule

// File: rtl/canbt_ctrl.sv
module canbt_ctrl
  import canbt_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int SEG1_W = 5,
  parameter int SEG2_W = 4,
  parameter int SJW_W  = 3,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  cfgPrescale,
  input  logic [SEG1_W-1:0] cfgTseg1,
  input  logic [SEG2_W-1:0] cfgTseg2,
  input  logic [SJW_W-1:0]  cfgSjw,
  input  logic              hardSyncEn,
  input  logic              lineFall,
  input  logic              rxBit,
  output strobes_t          strb,
  output logic              bitStart,
  output logic              cfgErr
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] q, seg1Last, bitLast;
  logic [CNT_W-1:0] t1E, baseLast, sjwE, ext, err2, cutLast;
  logic syncUsed, tick, edgeNow, inSeg1, inSeg2;
  logic lateNow, earlyNow, hardNow, restart, shorten, sampleNow;

  // configuration limits
  always_comb begin
    int t1, t2, sj, tot;
    t1  = int'(cfgTseg1);
    t2  = int'(cfgTseg2);
    sj  = int'(cfgSjw);
    tot = 1 + t1 + t2;
    cfgErr = !(t1 >= SEG1_MIN && t1 <= SEG1_MAX && t2 >= SEG2_MIN && t2 <= SEG2_MAX &&
               sj >= JUMP_MIN && sj <= JUMP_MAX && t2 >= sj && t1 > t2 &&
               tot >= BIT_MIN && tot <= BIT_MAX);
  end

  always_comb begin
    t1E       = CNT_W'(cfgTseg1);
    sjwE      = CNT_W'(cfgSjw);
    baseLast  = CNT_W'(cfgTseg1) + CNT_W'(cfgTseg2);
    tick      = !cfgErr && (preCnt == cfgPrescale);
    edgeNow   = tick && lineFall && !syncUsed;
    inSeg1    = (q != '0) && (q <= seg1Last);
    inSeg2    = (q != '0) && (q > seg1Last);
    hardNow   = edgeNow && hardSyncEn;
    lateNow   = edgeNow && !hardSyncEn && inSeg1;
    earlyNow  = edgeNow && !hardSyncEn && inSeg2 && rxBit;
    ext       = (q < sjwE) ? q : sjwE;
    err2      = bitLast - q + CNT_W'(1);
    cutLast   = bitLast - sjwE;
    restart   = hardNow || (earlyNow && err2 <= sjwE);
    shorten   = earlyNow && (err2 > sjwE);
    sampleNow = tick && (q != '0) && (q == seg1Last) && !lateNow && !hardNow;
    bitStart  = tick && ((q == '0) || restart);
  end

  assign strb.idle   = cfgErr;
  assign strb.tick   = tick;
  assign strb.sample = sampleNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0; q <= '0; seg1Last <= '0; bitLast <= '0; syncUsed <= 1'b0;
    end else if (cfgErr) begin
      preCnt <= '0; q <= '0; seg1Last <= '0; bitLast <= '0; syncUsed <= 1'b0;
    end else if (tick) begin
      preCnt <= '0;
      if (restart) begin
        q <= CNT_W'(1); seg1Last <= t1E; bitLast <= baseLast; syncUsed <= 1'b1;
      end else if (q == '0) begin
        q <= CNT_W'(1); seg1Last <= t1E; bitLast <= baseLast;
      end else if (lateNow) begin
        q <= q + CNT_W'(1);
        seg1Last <= seg1Last + ext;
        bitLast  <= bitLast + ext;
        syncUsed <= 1'b1;
      end else if (shorten) begin
        if (cutLast == q) begin
          q <= '0; syncUsed <= 1'b0;
        end else begin
          q <= q + CNT_W'(1); bitLast <= cutLast; syncUsed <= 1'b1;
        end
      end else if (q >= bitLast) begin
        q <= '0; syncUsed <= 1'b0;
      end else begin
        q <= q + CNT_W'(1);
      end
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleNow, bitStart}));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> (q == '0 && preCnt == '0));

  // R2
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rstN || cfgErr)
    q <= bitLast);

  // R6
  seg1_cap_chk: assert property (@(posedge clk) disable iff (!rstN || cfgErr)
    seg1Last <= t1E + sjwE);

  // R8
  one_sync_chk: assert property (@(posedge clk) disable iff (!rstN || cfgErr)
    (tick && syncUsed && q != '0 && q < bitLast) |=> (q == $past(q) + CNT_W'(1)));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import canbt_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int SEG1_W = 5,
  parameter int SEG2_W = 4,
  parameter int SJW_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  cfgPrescale,
  input  logic [SEG1_W-1:0] cfgTseg1,
  input  logic [SEG2_W-1:0] cfgTseg2,
  input  logic [SJW_W-1:0]  cfgSjw,
  input  logic              cfgTriple,
  input  logic              cfgHardSyncEn,
  input  logic              rxIn,
  output logic              rxBit,
  output logic              samplePulse,
  output logic              bitStart,
  output logic              cfgErr
);
  localparam int CNT_W = SEG1_W + 1;

  strobes_t strb;
  logic     lineFall;

  canbt_ctrl #(
    .PRE_W(PRE_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgPrescale(cfgPrescale), .cfgTseg1(cfgTseg1),
    .cfgTseg2(cfgTseg2), .cfgSjw(cfgSjw), .hardSyncEn(cfgHardSyncEn),
    .lineFall(lineFall), .rxBit(rxBit), .strb(strb), .bitStart(bitStart),
    .cfgErr(cfgErr)
  );

  canbt_dp uDp (
    .clk(clk), .rstN(rstN), .cfgTriple(cfgTriple), .rxIn(rxIn), .strb(strb),
    .lineFall(lineFall), .rxBit(rxBit)
  );

  assign samplePulse = strb.sample;
endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic [7:0] cfgPrescale = 8'd3;
  logic [4:0] cfgTseg1 = 5'd6;
  logic [3:0] cfgTseg2 = 4'd4;
  logic [2:0] cfgSjw = 3'd2;
  logic       cfgTriple = 1'b0, cfgHardSyncEn = 1'b0, rxIn = 1'b1;
  logic       rxBit, samplePulse, bitStart, cfgErr;

  can_bit_timer uut (
    .clk(clk), .rstN(rstN), .cfgPrescale(cfgPrescale), .cfgTseg1(cfgTseg1),
    .cfgTseg2(cfgTseg2), .cfgSjw(cfgSjw), .cfgTriple(cfgTriple),
    .cfgHardSyncEn(cfgHardSyncEn), .rxIn(rxIn), .rxBit(rxBit),
    .samplePulse(samplePulse), .bitStart(bitStart), .cfgErr(cfgErr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  localparam int P = 4, T1 = 6, T2 = 4, SJ = 2;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cfgOk(input int t1, input int t2, input int sj);
    return t1 >= 4 && t1 <= 16 && t2 >= 2 && t2 <= 8 && sj >= 1 && sj <= 4 &&
           t2 >= sj && t1 > t2 && (1 + t1 + t2) >= 8 && (1 + t1 + t2) <= 25;
  endfunction

  task automatic setup(input int pre, input int t1, input int t2, input int sj,
                       input bit tri3, input bit hs);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    cfgPrescale = 8'(pre); cfgTseg1 = 5'(t1); cfgTseg2 = 4'(t2); cfgSjw = 3'(sj);
    cfgTriple = tri3; cfgHardSyncEn = hs; rxIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitStart(output int c);
    do @(negedge clk); while (!bitStart);
    c = cyc;
  endtask

  task automatic waitSample(output int c);
    do @(negedge clk); while (!samplePulse);
    c = cyc;
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic settle(input bit lvl);
    int c;
    rxIn = lvl;
    for (int i = 0; i < 3; i++) waitStart(c);
  endtask

  task automatic quiet(input string req);
    int bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (samplePulse || bitStart || !rxBit) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int n, s, m;
    void'($urandom(32'd4242));

    // reset state (R4, R1)
    setup(P - 1, T1, T2, SJ, 1'b0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    chk(rxBit == 1'b1, "R4 reset rxBit", rxBit, 1);
    chk(!samplePulse && !bitStart, "R3 reset strobes", {samplePulse, bitStart}, 0);
    chk(cfgErr == 1'b0, "R1 valid cfg", cfgErr, 0);
    rstN = 1'b1;

    // R2 / R3 nominal timing
    waitStart(n);
    waitSample(s);
    chk(s - n == T1 * P, "R3 sample offset", s - n, T1 * P);
    waitStart(m);
    chk(m - n == (1 + T1 + T2) * P, "R2 bit period", m - n, (1 + T1 + T2) * P);

    // R6 late edge k=1
    settle(1'b1);
    waitStart(n);
    rxIn = 1'b0;
    waitSample(s);
    chk(s - n == (T1 + 1) * P, "R6 late k=1 sample", s - n, (T1 + 1) * P);
    @(negedge clk);
    chk(rxBit == 1'b0, "R4 dominant sampled", rxBit, 0);
    waitStart(m);
    chk(m - n == (T1 + T2 + 2) * P, "R6 late k=1 bit", m - n, (T1 + T2 + 2) * P);

    // R6 late edge k=4 capped at SJ; also edge in sample TQ (k=T1)
    settle(1'b1);
    chk(rxBit == 1'b1, "R4 recessive sampled", rxBit, 1);
    waitStart(n);
    waitCyc(n + 3 * P);
    rxIn = 1'b0;
    waitSample(s);
    chk(s - n == (T1 + SJ) * P, "R6 late k=4 capped", s - n, (T1 + SJ) * P);
    settle(1'b1);
    waitStart(n);
    waitCyc(n + (T1 - 1) * P);
    rxIn = 1'b0;
    waitSample(s);
    chk(s - n == (T1 + SJ) * P, "R6 edge in sample TQ", s - n, (T1 + SJ) * P);

    // R7 early edge in last TQ: immediate restart
    settle(1'b1);
    waitStart(n);
    waitCyc(n + (T1 + T2 - 1) * P);
    rxIn = 1'b0;
    waitStart(m);
    chk(m - n == (T1 + T2) * P, "R7 restart", m - n, (T1 + T2) * P);

    // R7 early edge in first seg2 TQ: shortened by SJ
    settle(1'b1);
    waitStart(n);
    waitCyc(n + T1 * P);
    rxIn = 1'b0;
    waitStart(m);
    chk(m - n == (T1 + T2 + 1 - SJ) * P, "R7 shorten", m - n, (T1 + T2 + 1 - SJ) * P);

    // R8 second edge in same bit ignored
    settle(1'b1);
    waitStart(n);
    rxIn = 1'b0;
    waitCyc(n + P + 1);
    rxIn = 1'b1;
    waitCyc(n + (T1 + 2) * P);
    rxIn = 1'b0;
    waitStart(m);
    chk(m - n == (T1 + T2 + 2) * P, "R8 one sync per bit", m - n, (T1 + T2 + 2) * P);

    // R10 seg2 edge ignored after dominant sample
    settle(1'b0);
    waitStart(n);
    waitCyc(n + T1 * P + 1);
    rxIn = 1'b1;
    waitCyc(n + (T1 + 1) * P + 1);
    rxIn = 1'b0;
    waitStart(m);
    chk(m - n == (T1 + T2 + 1) * P, "R10 dominant blocks", m - n, (T1 + T2 + 1) * P);

    // R4 single mode: one-TQ recessive glitch at sample TQ
    settle(1'b0);
    waitStart(n);
    waitCyc(n + (T1 - 1) * P + 1);
    rxIn = 1'b1;
    waitCyc(n + T1 * P + 1);
    rxIn = 1'b0;
    waitCyc(n + T1 * P + 2);
    chk(rxBit == 1'b1, "R4 single glitch", rxBit, 1);

    // R5 triple mode
    setup(P - 1, T1, T2, SJ, 1'b1, 1'b0);
    settle(1'b0);
    waitStart(n);
    waitCyc(n + (T1 - 1) * P + 1);
    rxIn = 1'b1;
    waitCyc(n + T1 * P + 1);
    rxIn = 1'b0;
    waitCyc(n + T1 * P + 2);
    chk(rxBit == 1'b0, "R5 majority one of three", rxBit, 0);
    settle(1'b0);
    waitStart(n);
    waitCyc(n + (T1 - 2) * P + 1);
    rxIn = 1'b1;
    waitCyc(n + T1 * P + 1);
    rxIn = 1'b0;
    waitCyc(n + T1 * P + 2);
    chk(rxBit == 1'b1, "R5 majority two of three", rxBit, 1);

    // R9 hard sync
    setup(P - 1, T1, T2, SJ, 1'b0, 1'b1);
    settle(1'b1);
    waitStart(n);
    waitCyc(n + 2 * P);
    rxIn = 1'b0;
    waitStart(m);
    chk(m - n == 3 * P, "R9 hard sync start", m - n, 3 * P);
    waitSample(s);
    chk(s - m == T1 * P, "R9 sample after hard sync", s - m, T1 * P);

    // R1 directed illegal settings and boundaries
    setup(3, 4, 4, 2, 1'b0, 1'b0);
    chk(cfgErr == 1'b1, "R1 tseg1 not above tseg2", cfgErr, 1);
    quiet("R1 idle tseg1<=tseg2");
    setup(3, 8, 2, 3, 1'b0, 1'b0);
    chk(cfgErr == 1'b1, "R1 sjw above tseg2", cfgErr, 1);
    setup(3, 4, 2, 1, 1'b0, 1'b0);
    chk(cfgErr == 1'b1, "R1 bit too short", cfgErr, 1);
    quiet("R1 idle short bit");
    setup(0, 16, 8, 4, 1'b0, 1'b0);
    chk(cfgErr == 1'b0, "R1 max bit legal", cfgErr, 0);
    waitStart(n);
    waitStart(m);
    chk(m - n == 25, "R2 25 TQ at prescale 1", m - n, 25);
    setup(255, 5, 2, 1, 1'b0, 1'b0);
    waitStart(n);
    waitStart(m);
    chk(m - n == 8 * 256, "R2 prescale 256", m - n, 8 * 256);

    // random configurations
    for (int it = 0; it < 14; it++) begin
      int pr, a, b, j;
      bit ok;
      pr = int'($urandom % 8);
      a  = 3 + int'($urandom % 15);
      b  = 1 + int'($urandom % 9);
      j  = int'($urandom % 6);
      ok = cfgOk(a, b, j);
      setup(pr, a, b, j, 1'($urandom % 2), 1'b0);
      @(negedge clk);
      chk(cfgErr == !ok, "R1 random validity", cfgErr, !ok);
      if (ok) begin
        waitStart(n);
        waitSample(s);
        chk(s - n == a * (pr + 1), "R3 random sample offset", s - n, a * (pr + 1));
        waitStart(m);
        chk(m - n == (1 + a + b) * (pr + 1), "R2 random period", m - n, (1 + a + b) * (pr + 1));
      end else begin
        quiet("R1 random idle");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule